// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is the device side of a tiny serial EEPROM that sits on a two-wire (I2C) bus and holds 16 bytes. The design runs on a fast system clock. It oversamples the clock and data lines, finds start, repeated-start and stop conditions, and then works through the bus protocol. When the target needs to drive the data line it asserts a pull-low enable, and the pad outside the block turns that into an open-drain output.

Every transaction opens with an 8-bit control byte. The high nibble of that byte is the device tag 1010. The next three bits are ignored, and the lowest bit selects direction, where 1 means read.

- **Write direction.** A word address follows the control byte, and after it come data bytes that are stored one by one.
- **Read direction.** The target sends the byte at its internal pointer, and keeps sending successive bytes for as long as the controller acknowledges.
- **Random read.** The controller sends a write control byte and a word address. It then issues a repeated start and a read control byte. The pointer keeps the loaded address across the repeated start.

The pointer also carries over between transactions. It counts modulo 16.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the pull-low enable is deasserted, every byte of storage reads 0x00, and the pointer is 0. A current-address read right after reset therefore returns 0x00.
- R2: The target acknowledges (pulls SDA low in the ninth clock) any control byte whose bits 7..4 are 1010, and it ignores bits 3..1. A control byte with any other high nibble gets no acknowledge. The target then leaves SDA released, so all bits read as 1, until the next start.
- R3: In the write direction, the target acknowledges the word address, and only its low four bits select the location. Each following data byte is acknowledged, stored at the pointer, and the pointer then advances by one.
- R4: In the read direction, the target sends the byte at the pointer, MSB first, starting right after the control-byte acknowledge. The pointer advances by one when each sent byte completes, so a later current-address read continues from where the last access left off.
- R5: A write control byte and word address, followed by a repeated start and a read control byte, returns the byte at that word address. The aborted write stores nothing.
- R6: If the controller acknowledges a read byte, the next sequential byte follows. The pointer wraps from 15 to 0. A not-acknowledge followed by stop ends the transfer.
- R7: The pull-low enable changes only while the synchronized SCL is low.
- R8: After a stop condition the target releases SDA and waits for a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release it |

## Verification
The assertions take for granted a well-behaved controller. It changes SDA only while SCL is low, except when it is making a start or stop. It never issues a start or stop while the target is pulling SDA low. It also holds each SCL phase for many system clocks, so that synchronized edges never merge.

The bench's bus tasks keep SCL low or high for ten system clocks per quarter bit. They place every controller data transition in the middle of the low phase. They only create starts and stops when the target has released the line, that is, after an acknowledge clock or after a not-acknowledged read byte.

// File: rtl/eep_tgt_pkg.sv
package eep_tgt_pkg;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned BIT_W  = $clog2(DATA_W);
  localparam logic [3:0]  DEV_TAG = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic [STAGES-1:0] scl_sh_n, sda_sh_n;
  logic              scl_d, sda_d;

  always_comb begin
    scl_sh_n = {scl_sh[STAGES-2:0], scl_i};
    sda_sh_n = {sda_sh[STAGES-2:0], sda_i};
  end

  // Idle bus is high on both lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= scl_sh_n;
      sda_sh <= sda_sh_n;
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_n;
  logic          ptr_en;

  always_comb begin
    ptr_en = inc | load;
    if (load)              ptr_n = load_val;
    else if (ptr == LAST)  ptr_n = '0;
    else                   ptr_n = ptr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_n;
  end

endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_tgt_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] row_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic row_en;
    assign row_en = wr_en & (addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q[i] <= '0;
      else if (row_en) row_q[i] <= wr_data;
    end
  end

  assign rd_data = row_q[addr];

endmodule

// File: rtl/eep_tgt_fsm.sv
module eep_tgt_fsm
  import eep_tgt_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sda_pull,
  output logic              ptr_inc,
  output logic              ptr_load,
  output logic [AW-1:0]     load_val,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              idle
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  tgt_state_e        state, state_n;
  logic [BIT_W-1:0]  bcnt, bcnt_n;
  logic [DATA_W-1:0] rx_q, rx_n;
  logic [DATA_W-1:0] tx_q, tx_n;
  logic              pull_q, pull_n;
  logic              full_q, full_n;
  logic              rd_q, rd_n;
  logic              ack_q, ack_n;

  always_comb begin
    state_n  = state;
    bcnt_n   = bcnt;
    rx_n     = rx_q;
    tx_n     = tx_q;
    pull_n   = pull_q;
    full_n   = full_q;
    rd_n     = rd_q;
    ack_n    = ack_q;
    ptr_inc  = 1'b0;
    ptr_load = 1'b0;
    wr_en    = 1'b0;
    if (stop_evt) begin
      state_n = ST_IDLE;
      pull_n  = 1'b0;
      full_n  = 1'b0;
    end else if (start_evt) begin
      state_n = ST_CTRL;
      pull_n  = 1'b0;
      full_n  = 1'b0;
      bcnt_n  = '0;
    end else begin
      unique case (state)
        ST_CTRL, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            rx_n = {rx_q[DATA_W-2:0], sda_lvl};
            if (bcnt == LAST_BIT) full_n = 1'b1;
            else                  bcnt_n = bcnt + BIT_W'(1);
          end else if (scl_fall && full_q) begin
            full_n = 1'b0;
            bcnt_n = '0;
            if (state == ST_CTRL) begin
              if (rx_q[DATA_W-1 -: 4] == DEV_TAG) begin
                pull_n  = 1'b1;
                rd_n    = rx_q[0];
                state_n = ST_CTRL_ACK;
              end else begin
                state_n = ST_IDLE;
              end
            end else if (state == ST_WADDR) begin
              pull_n   = 1'b1;
              ptr_load = 1'b1;
              state_n  = ST_WADDR_ACK;
            end else begin
              pull_n  = 1'b1;
              wr_en   = 1'b1;
              ptr_inc = 1'b1;
              state_n = ST_WDATA_ACK;
            end
          end
        end
        ST_CTRL_ACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              tx_n    = rd_data;
              pull_n  = ~rd_data[DATA_W-1];
              bcnt_n  = '0;
              state_n = ST_RDATA;
            end else begin
              pull_n  = 1'b0;
              state_n = ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            pull_n  = 1'b0;
            state_n = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bcnt == LAST_BIT) begin
              pull_n  = 1'b0;
              ptr_inc = 1'b1;
              state_n = ST_RACK;
            end else begin
              bcnt_n = bcnt + BIT_W'(1);
              tx_n   = {tx_q[DATA_W-2:0], 1'b0};
              pull_n = ~tx_q[DATA_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            ack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (ack_q) begin
              tx_n    = rd_data;
              pull_n  = ~rd_data[DATA_W-1];
              bcnt_n  = '0;
              state_n = ST_RDATA;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bcnt   <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      pull_q <= 1'b0;
      full_q <= 1'b0;
      rd_q   <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      state  <= state_n;
      bcnt   <= bcnt_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      pull_q <= pull_n;
      full_q <= full_n;
      rd_q   <= rd_n;
      ack_q  <= ack_n;
    end
  end

  assign sda_pull = pull_q;
  assign load_val = rx_q[AW-1:0];
  assign wr_data  = rx_q;
  assign idle     = (state == ST_IDLE);

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eep_tgt_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic [1:0]        rst_q;
  logic              rst_sync_n;
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic              ptr_inc, ptr_load, wr_en, fsm_idle;
  logic [AW-1:0]     ptr, load_val;
  logic [DATA_W-1:0] rd_data, wr_data;

  // Reset asserts at once and deasserts after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eep_addr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .inc(ptr_inc), .load(ptr_load),
    .load_val(load_val), .ptr(ptr)
  );

  eep_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(ptr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  eep_tgt_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .sda_pull(sda_pull_o), .ptr_inc(ptr_inc),
    .ptr_load(ptr_load), .load_val(load_val), .wr_en(wr_en),
    .wr_data(wr_data), .idle(fsm_idle)
  );

endmodule

// File: rtl/eep_target_checker.sv
module eep_target_checker #(
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_lvl,
  input logic          stop_evt,
  input logic          sda_pull,
  input logic          fsm_idle,
  input logic          ptr_inc,
  input logic          ptr_load,
  input logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] LAST = '1;

  p_pull_moves_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_lvl);

  p_release_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_idle |-> !sda_pull);

  p_ptr_moves_on_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptr) |-> $past(ptr_inc || ptr_load));

  p_ptr_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr_inc) && $past(ptr) == LAST && !$past(ptr_load)) |-> ptr == '0);

  p_inc_load_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ptr_inc && ptr_load));

endmodule

bind i2c_eeprom_target eep_target_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_lvl(scl_lvl), .stop_evt(stop_evt),
  .sda_pull(sda_pull_o), .fsm_idle(fsm_idle), .ptr_inc(ptr_inc),
  .ptr_load(ptr_load), .ptr(ptr)
);

// File: tb/tb_i2c_eeprom_target.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_target;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic ctl_low = 1'b0;
  logic sda_pull_o;
  wire  sda_bus = ~(ctl_low | sda_pull_o);

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] mem_m [16];
  logic [3:0] ptr_m;

  always #5 clk = ~clk;

  i2c_eeprom_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    ctl_low = ~b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask

  task automatic bit_in(output logic b);
    ctl_low = 1'b0; qw(); scl = 1'b1; qw(); b = sda_bus; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_start();
    ctl_low = 1'b0; qw(); scl = 1'b1; qw(); ctl_low = 1'b1; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    ctl_low = 1'b1; qw(); scl = 1'b1; qw(); ctl_low = 1'b0; qw(); qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~give_ack);
  endtask

  function automatic logic [7:0] ctrl_byte(input logic rd);
    return {4'b1010, 3'($urandom_range(0, 7)), rd};
  endfunction

  task automatic read_run(input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      chk((i > 0) ? "R6 sequential byte" : "R4 read byte", d, mem_m[ptr_m]);
      ptr_m = ptr_m + 4'd1;
    end
    bus_stop();
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [7:0] data);
    logic ack;
    bus_start();
    send_byte(ctrl_byte(1'b0), ack); chk("R2 ctrl ack", ack, 1'b1);
    send_byte(addr, ack);            chk("R3 addr ack", ack, 1'b1);
    send_byte(data, ack);            chk("R3 data ack", ack, 1'b1);
    bus_stop();
    mem_m[addr[3:0]] = data;
    ptr_m = addr[3:0] + 4'd1;
  endtask

  task automatic do_cur_read(input int n);
    logic ack;
    bus_start();
    send_byte(ctrl_byte(1'b1), ack); chk("R2 ctrl ack read", ack, 1'b1);
    read_run(n);
  endtask

  task automatic do_rand_read(input logic [7:0] addr, input int n);
    logic ack;
    bus_start();
    send_byte(ctrl_byte(1'b0), ack); chk("R2 ctrl ack", ack, 1'b1);
    send_byte(addr, ack);            chk("R5 addr ack", ack, 1'b1);
    bus_start();
    send_byte(ctrl_byte(1'b1), ack); chk("R5 ctrl ack after restart", ack, 1'b1);
    ptr_m = addr[3:0];
    read_run(n);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 16; i++) mem_m[i] = 8'h00;
    ptr_m = 4'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 pull released at reset", sda_pull_o, 1'b0);
    // R1: first current read gets address 0, which holds zero
    do_cur_read(2);

    // R3: upper nibble of word address ignored
    do_write(8'hF5, 8'h3C);
    do_write(8'h06, 8'hA7);
    // R4: current read continues at 7
    do_cur_read(1);
    do_rand_read(8'h35, 2);

    // R2: bad tag not acknowledged, bus stays released
    bus_start();
    send_byte(8'hB1, ack); chk("R2 foreign tag nack", ack, 1'b0);
    for (int i = 7; i >= 0; i--) begin bit_in(d[i]); end
    chk("R2 bus released", d, 8'hFF);
    bit_out(1'b1);
    bus_stop();
    chk("R8 pull released after stop", sda_pull_o, 1'b0);
    do_cur_read(1); // pointer untouched by the ignored byte

    // R6: wrap from 15 to 0
    do_write(8'h0F, 8'h9E);
    do_write(8'h00, 8'h11);
    do_rand_read(8'h0E, 4);
    // R6: whole array in one transfer
    do_rand_read(8'h00, 16);

    // R5: aborted write leaves location 9 untouched
    do_write(8'h09, 8'h5A);
    bus_start();
    send_byte(ctrl_byte(1'b0), ack); chk("R5 ctrl ack", ack, 1'b1);
    send_byte(8'h02, ack);           chk("R5 addr ack", ack, 1'b1);
    bus_stop();
    ptr_m = 4'd2;
    do_rand_read(8'h09, 1);

    for (int n = 0; n < 24; n++) begin
      case ($urandom_range(0, 2))
        0: do_write(8'($urandom), 8'($urandom));
        1: do_cur_read($urandom_range(1, 3));
        default: do_rand_read(8'($urandom), $urandom_range(1, 4));
      endcase
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule